// File: doc/BRIEF.md
# Phase Edge Search Sequencer

This block runs a closed-loop search that lines a derived clock up with a bus clock. It owns a 6-bit phase-control value. For each adjustment it writes that value to an external phase shifter, waits a settle time, flips a load strobe, and then reads a 1-bit phase comparator. The shifter and the comparator sit outside the block. The sequencer first hunts for a falling comparator transition. It then confirms that transition with a forward probe and a backward probe. Last, it finds the edge a second time and parks the phase one step before it.

Software or a boot sequencer pulses `start` with a starting phase. When the run ends, `done` (success) or `fail` is raised together with the number of counted adjustments. All three stay as they are until the next `start`. An attempt that looks false is retried from the last phase written. The number of attempts and the total number of adjustments are both bounded.

Top module: `phase_edge_aligner`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are 0, `adjust_count` is 0, `phase_out` is 0 and `load_tgl` is 0.
- R2: Each adjustment is a load. The block writes `phase_out` and keeps it unchanged for at least SETTLE_CYC clock cycles. It then inverts `load_tgl` and samples `cmp_in` two cycles after the inversion. `phase_out` does not change between the write and the sample.
- R3: Every step of the phase is +1 or -1 modulo 64, so 63+1 gives 0 and 0-1 gives 63.
- R4: The search rewrites the current phase first. After each sample it moves down one step if the comparator read 0 and up one step if it read 1. It stops only on a falling transition: the previous reading was 1 and the new reading is 0. For the first load of a search, the previous reading is `cmp_in` at `start` in the first attempt and the last sample in later attempts.
- R5: The forward probe loads the found edge and then steps up by one, for at most FWD_STEPS (5) loads in total, while the comparator reads 0. If the comparator still reads 0 after the fifth load, the attempt is false and a new one starts from the last phase written.
- R6: The first backward probe steps down only while the comparator reads 0. The forward probe ends only with the comparator at 1, so this probe takes no loads.
- R7: The block then makes exactly BACK_STEPS (5) downward loads. If the comparator reads 0 after them, the attempt is false. Otherwise the edge is searched for again with the R4 rule.
- R8: On success, the final phase is the last phase written minus 1 (mod 64). It is written and loaded, and then `done` goes to 1. `adjust_count` holds the number of loads made before the final load. With a comparator that reads 0 only on a window of W phases starting at E (W up to 4), the expected count is ((E-s) mod 64)+13 for a start phase s outside the window, and k+15 for a start phase at offset k inside the window. The final phase is E-1.
- R9: At most MAX_ATTEMPTS (10) attempts are made. If the tenth attempt is also false, `fail` is raised.
- R10: If the counted loads reach ADJ_LIMIT, the run stops with `fail`=1 and `adjust_count`=ADJ_LIMIT. This also applies when the limit is hit on the load that would otherwise have completed the search.
- R11: `done` and `fail` are never both 1. `done`, `fail`, `adjust_count` and `phase_out` hold until the next `start`. A `start` pulse that arrives while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run (ignored while busy) |
| phase_init | input | 6 | Starting phase value, sampled with `start` |
| cmp_in | input | 1 | Phase comparator output |
| phase_out | output | 6 | Phase value presented to the shifter |
| load_tgl | output | 1 | Load strobe; inverts once per load |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished with an aligned phase |
| fail | output | 1 | Run finished without alignment |
| adjust_count | output | 16 | Counted loads of the last run |

## Verification
The bench models the comparator as a 64-bit map of phase to reading. A full sweep of all 64 start phases against a 3-wide zero window separates the two ways into the search: starting inside the window (count k+15) and starting outside it (count d+13). A second sweep uses a 4-wide window that straddles 63/0. It exercises modulo wrap and shows that a fifth forward load reading 1 still passes. A 5-wide window keeps the forward probe at 0 and must exhaust all ten attempts. A map with a second isolated zero four phases below the edge makes the backward probe fail once and then succeed on a moved edge. A second instance with a limit of 20 separates the count that just completes the search (19) from the count that hits the limit (20).

// File: rtl/pea_pkg.sv
`timescale 1ns/1ps
// Shared state encodings for the phase edge search sequencer.
package pea_pkg;
    // States of the single-load engine.
    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SETTLE,
        ENG_CAPT,
        ENG_SAMPLE
    } eng_state_t;

    // Stages of the search controller.
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SEARCH,
        SEQ_FWD,
        SEQ_BACK,
        SEQ_REDISC,
        SEQ_FINAL
    } seq_state_t;
endpackage

// File: rtl/pea_step_engine.sv
`timescale 1ns/1ps
// Performs one phase load per request.
// It drives the new phase, holds it for SETTLE_CYC cycles and inverts the load strobe.
// It then allows one cycle for the shifter to capture the value and samples the comparator.
// Assumes: go arrives only while the engine is idle, and the comparator has settled
// one cycle after the shifter captures the value.
module pea_step_engine
    import pea_pkg::*;
#(
    parameter int PHASE_W    = 6,
    parameter int SETTLE_CYC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [PHASE_W-1:0] go_phase,
    input  logic               cmp_in,
    output logic [PHASE_W-1:0] phase_out,
    output logic               load_tgl,
    output logic               step_done,
    output logic               step_cmp
);
    localparam int SET_W = $clog2(SETTLE_CYC + 1);

    eng_state_t         state;
    logic [SET_W-1:0]   wait_cnt;
    logic [PHASE_W-1:0] phase_q;
    logic               tgl_q;

    // Sequence one load: write, settle, strobe, capture slot, sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            wait_cnt <= '0;
            phase_q  <= '0;
            tgl_q    <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: if (go) begin
                    phase_q  <= go_phase;
                    wait_cnt <= SET_W'(SETTLE_CYC - 1);
                    state    <= ENG_SETTLE;
                end
                ENG_SETTLE: if (wait_cnt == '0) begin
                    tgl_q <= ~tgl_q;
                    state <= ENG_CAPT;
                end else begin
                    wait_cnt <= wait_cnt - 1'b1;
                end
                ENG_CAPT:   state <= ENG_SAMPLE;
                default:    state <= ENG_IDLE;
            endcase
        end
    end

    assign phase_out = phase_q;
    assign load_tgl  = tgl_q;
    assign step_done = (state == ENG_SAMPLE);
    assign step_cmp  = cmp_in;

    // Track how long the driven phase has been unchanged, for the settle check.
    logic [PHASE_W-1:0] phase_seen;
    logic [SET_W-1:0]   age;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_seen <= '0;
            age        <= '0;
        end else begin
            phase_seen <= phase_q;
            if (phase_q != phase_seen)
                age <= SET_W'(1);
            else if (age != SET_W'(SETTLE_CYC))
                age <= age + 1'b1;
        end
    end

    // R2
    settle_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_tgl != $past(load_tgl)) |-> ($past(age) >= SET_W'(SETTLE_CYC - 1)));

    // R2
    phase_held_to_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_CAPT || state == ENG_SAMPLE) |-> $stable(phase_q));
endmodule

// File: rtl/pea_search_ctrl.sv
`timescale 1ns/1ps
// Stage controller for the edge search. It runs search, forward probe, backward probe and
// rediscovery, retries false transitions and enforces the attempt and load limits.
// Assumes: step_done pulses once per requested load, and phase_now is the value loaded.
module pea_search_ctrl
    import pea_pkg::*;
#(
    parameter int PHASE_W      = 6,
    parameter int CNT_W        = 16,
    parameter int FWD_STEPS    = 5,
    parameter int BACK_STEPS   = 5,
    parameter int MAX_ATTEMPTS = 10,
    parameter int ADJ_LIMIT    = 65535
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PHASE_W-1:0] phase_init,
    input  logic               cmp_in,
    input  logic               step_done,
    input  logic               step_cmp,
    input  logic [PHASE_W-1:0] phase_now,
    output logic               go,
    output logic [PHASE_W-1:0] go_phase,
    output logic               busy,
    output logic               done,
    output logic               fail,
    output logic [CNT_W-1:0]   adjust_count
);
    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
    localparam int PRB_W = $clog2(FWD_STEPS + BACK_STEPS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ADJ_LIMIT);

    seq_state_t         state;
    logic               prev_q;
    logic [CNT_W-1:0]   adj_q;
    logic [ATT_W-1:0]   att_q;
    logic [PRB_W-1:0]   cnt_q;
    logic               go_q;
    logic [PHASE_W-1:0] go_phase_q;
    logic               done_q;
    logic               fail_q;

    logic [PHASE_W-1:0] w_inc, w_dec;
    logic [CNT_W-1:0]   adj_inc;
    logic [ATT_W-1:0]   att_inc;
    assign w_inc   = phase_now + 1'b1;
    assign w_dec   = phase_now - 1'b1;
    assign adj_inc = adj_q + 1'b1;
    assign att_inc = att_q + 1'b1;

    // Advance the stage machine on start and on each completed load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            prev_q     <= 1'b0;
            adj_q      <= '0;
            att_q      <= '0;
            cnt_q      <= '0;
            go_q       <= 1'b0;
            go_phase_q <= '0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
        end else begin
            go_q <= 1'b0;
            case (state)
                SEQ_IDLE: if (start) begin
                    prev_q     <= cmp_in;
                    adj_q      <= '0;
                    att_q      <= '0;
                    cnt_q      <= '0;
                    done_q     <= 1'b0;
                    fail_q     <= 1'b0;
                    go_q       <= 1'b1;
                    go_phase_q <= phase_init;
                    state      <= SEQ_SEARCH;
                end
                SEQ_FINAL: if (step_done) begin
                    done_q <= 1'b1;
                    state  <= SEQ_IDLE;
                end
                default: if (step_done) begin
                    adj_q <= adj_inc;
                    if (adj_inc == LIMIT) begin
                        fail_q <= 1'b1;
                        state  <= SEQ_IDLE;
                    end else if (state == SEQ_SEARCH || state == SEQ_REDISC) begin
                        prev_q <= step_cmp;
                        go_q   <= 1'b1;
                        if (prev_q && !step_cmp) begin
                            if (state == SEQ_REDISC) begin
                                go_phase_q <= w_dec;
                                state      <= SEQ_FINAL;
                            end else begin
                                go_phase_q <= phase_now;
                                cnt_q      <= PRB_W'(1);
                                state      <= SEQ_FWD;
                            end
                        end else begin
                            go_phase_q <= step_cmp ? w_inc : w_dec;
                        end
                    end else if (state == SEQ_FWD && step_cmp) begin
                        // Comparator is 1: the first backward probe has nothing to do.
                        go_q       <= 1'b1;
                        go_phase_q <= w_dec;
                        cnt_q      <= PRB_W'(1);
                        state      <= SEQ_BACK;
                    end else if (state == SEQ_FWD && cnt_q != PRB_W'(FWD_STEPS)) begin
                        go_q       <= 1'b1;
                        go_phase_q <= w_inc;
                        cnt_q      <= cnt_q + 1'b1;
                    end else if (state == SEQ_BACK && cnt_q != PRB_W'(BACK_STEPS)) begin
                        go_q       <= 1'b1;
                        go_phase_q <= w_dec;
                        cnt_q      <= cnt_q + 1'b1;
                    end else if (state == SEQ_BACK && step_cmp) begin
                        prev_q     <= step_cmp;
                        go_q       <= 1'b1;
                        go_phase_q <= phase_now;
                        state      <= SEQ_REDISC;
                    end else if (att_inc == ATT_W'(MAX_ATTEMPTS)) begin
                        fail_q <= 1'b1;
                        state  <= SEQ_IDLE;
                    end else begin
                        // False transition: restart the search from the last phase written.
                        att_q      <= att_inc;
                        prev_q     <= step_cmp;
                        go_q       <= 1'b1;
                        go_phase_q <= phase_now;
                        state      <= SEQ_SEARCH;
                    end
                end
            endcase
        end
    end

    assign go           = go_q;
    assign go_phase     = go_phase_q;
    assign busy         = (state != SEQ_IDLE);
    assign done         = done_q;
    assign fail         = fail_q;
    assign adjust_count = adj_q;

    // R11
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && fail_q));

    // R11
    result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(start)) |->
            ($stable(adj_q) && $stable(done_q) && $stable(fail_q)));

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (adj_q == $past(adj_q) || adj_q == $past(adj_q) + 1'b1));

    // R10
    no_success_at_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (adj_q < LIMIT));

    // R9
    attempt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        att_q < ATT_W'(MAX_ATTEMPTS));
endmodule

// File: rtl/phase_edge_aligner.sv
`timescale 1ns/1ps
// Top of the phase edge search sequencer: stage controller plus single-load engine.
// Assumes an external phase shifter that captures phase_out on either edge of load_tgl,
// and a comparator whose output cmp_in reflects the captured phase.
module phase_edge_aligner #(
    parameter int PHASE_W      = 6,
    parameter int CNT_W        = 16,
    parameter int SETTLE_CYC   = 5,
    parameter int FWD_STEPS    = 5,
    parameter int BACK_STEPS   = 5,
    parameter int MAX_ATTEMPTS = 10,
    parameter int ADJ_LIMIT    = 65535
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PHASE_W-1:0] phase_init,
    input  logic               cmp_in,
    output logic [PHASE_W-1:0] phase_out,
    output logic               load_tgl,
    output logic               busy,
    output logic               done,
    output logic               fail,
    output logic [CNT_W-1:0]   adjust_count
);
    logic               go;
    logic [PHASE_W-1:0] go_phase;
    logic               step_done;
    logic               step_cmp;

    pea_search_ctrl #(
        .PHASE_W(PHASE_W), .CNT_W(CNT_W), .FWD_STEPS(FWD_STEPS),
        .BACK_STEPS(BACK_STEPS), .MAX_ATTEMPTS(MAX_ATTEMPTS), .ADJ_LIMIT(ADJ_LIMIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .phase_init(phase_init),
        .cmp_in(cmp_in), .step_done(step_done), .step_cmp(step_cmp),
        .phase_now(phase_out), .go(go), .go_phase(go_phase), .busy(busy),
        .done(done), .fail(fail), .adjust_count(adjust_count)
    );

    pea_step_engine #(
        .PHASE_W(PHASE_W), .SETTLE_CYC(SETTLE_CYC)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .go_phase(go_phase), .cmp_in(cmp_in),
        .phase_out(phase_out), .load_tgl(load_tgl), .step_done(step_done),
        .step_cmp(step_cmp)
    );
endmodule

// File: tb/phase_edge_aligner_tb.sv
`timescale 1ns/1ps
// Bench: a phase-to-reading map models the comparator; two instances (full limit, limit 20).
module phase_edge_aligner_tb;
    localparam int SETTLE = 5;
    localparam int CAPLIM = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [5:0] init_ph = '0;
    logic [63:0] mask = '1;

    logic [5:0]  ph_a, ph_b;
    logic        tgl_a, tgl_b, busy_a, busy_b, done_a, done_b, fail_a, fail_b;
    logic [15:0] cnt_a, cnt_b;
    logic        cmp_a, cmp_b;

    logic [5:0] ld_a = '0, ld_b = '0;
    logic       td_a = 1'b0, td_b = 1'b0;
    int         loads_a = 0;
    logic       pre_en = 1'b0;
    logic [5:0] pre_val = '0;
    int         checks = 0, errors = 0, cyc = 0, settle_bad = 0;
    logic [5:0] ph_prev = '0;
    int         ph_age = 0;

    always #2 clk = ~clk;

    assign cmp_a = mask[ld_a];
    assign cmp_b = mask[ld_b];

    phase_edge_aligner u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .phase_init(init_ph), .cmp_in(cmp_a),
        .phase_out(ph_a), .load_tgl(tgl_a), .busy(busy_a), .done(done_a),
        .fail(fail_a), .adjust_count(cnt_a));

    phase_edge_aligner #(.ADJ_LIMIT(CAPLIM)) u_cap (
        .clk(clk), .rst_n(rst_n), .start(start), .phase_init(init_ph), .cmp_in(cmp_b),
        .phase_out(ph_b), .load_tgl(tgl_b), .busy(busy_b), .done(done_b),
        .fail(fail_b), .adjust_count(cnt_b));

    // Phase shifter model: capture on either strobe edge, count loads.
    always @(posedge clk) begin
        td_a <= tgl_a;
        td_b <= tgl_b;
        if (pre_en) begin
            ld_a <= pre_val; ld_b <= pre_val; loads_a <= 0;
        end else begin
            if (tgl_a != td_a) begin ld_a <= ph_a; loads_a <= loads_a + 1; end
            if (tgl_b != td_b) ld_b <= ph_b;
        end
    end

    // R2: settle time seen at the ports before each strobe flip.
    always @(posedge clk) begin
        ph_prev <= ph_a;
        if (ph_a != ph_prev) ph_age <= 1;
        else if (ph_age < 1000) ph_age <= ph_age + 1;
        if (tgl_a != td_a && ph_age < SETTLE) settle_bad <= settle_bad + 1;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=<190000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic set_window(input int e, input int w);
        mask = '1;
        for (int k = 0; k < w; k++) mask[6'(e + k)] = 1'b0;
    endtask

    task automatic run(input int s);
        @(negedge clk);
        pre_en = 1'b1; pre_val = 6'(s);
        @(negedge clk);
        pre_en = 1'b0;
        init_ph = 6'(s); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy_a || busy_b) @(negedge clk);
    endtask

    // Check both instances against an expected count and final phase.
    task automatic expect_run(input string tag, input int adj, input bit ok, input int fph);
        chk({tag, " done"}, int'(done_a), int'(ok));
        chk({tag, " fail"}, int'(fail_a), int'(!ok));
        chk({tag, " count"}, int'(cnt_a), adj);
        chk({tag, " loads"}, loads_a, ok ? adj + 1 : adj);
        if (ok) chk({tag, " phase"}, int'(ph_a), fph & 63);
        if (adj >= CAPLIM) begin
            chk({tag, " R10 cap fail"}, int'(fail_b), 1);
            chk({tag, " R10 cap count"}, int'(cnt_b), CAPLIM);
        end else begin
            chk({tag, " R10 below cap"}, int'(done_b), int'(ok));
            chk({tag, " R10 below cap count"}, int'(cnt_b), adj);
        end
    endtask

    function automatic int window_adj(input int e, input int w, input int s);
        int k = (s - e) & 63;
        if (k < w) return k + 15;
        return ((e - s) & 63) + 13;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy_a), 0);
        chk("R1 done", int'(done_a), 0);
        chk("R1 fail", int'(fail_a), 0);
        chk("R1 count", int'(cnt_a), 0);
        chk("R1 phase", int'(ph_a), 0);
        chk("R1 strobe", int'(tgl_a), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 R5 R6 R7 R8 R10: every start phase, 3-wide window at 20
        set_window(20, 3);
        for (int s = 0; s < 64; s++) begin
            run(s);
            expect_run("R4/R8 sweep w3", window_adj(20, 3, s), 1'b1, 19);
        end

        // R3 R5: 4-wide window straddling 63/0; fifth forward load reads 1
        set_window(62, 4);
        for (int s = 0; s < 64; s += 3) begin
            run(s);
            expect_run("R3/R5 wrap w4", window_adj(62, 4, s), 1'b1, 61);
        end

        // R5 R9: 5-wide window keeps forward probe at 0, ten attempts fail
        set_window(10, 5);
        run(0);
        expect_run("R5/R9 exhaust", 10 + 114, 1'b0, 0);

        // R7: second zero four below the edge fails the backward probe once
        mask = '1; mask[30] = 1'b0; mask[26] = 1'b0;
        run(27);
        expect_run("R7 back probe retry", 26, 1'b1, 25);

        // R11: start while busy is ignored; results then hold
        set_window(20, 3);
        @(negedge clk);
        pre_en = 1'b1; pre_val = 6'd5;
        @(negedge clk);
        pre_en = 1'b0; init_ph = 6'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        init_ph = 6'd40; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy_a || busy_b) @(negedge clk);
        expect_run("R11 start while busy", 28, 1'b1, 19);
        mask = '0;
        repeat (20) @(negedge clk);
        chk("R11 held done", int'(done_a), 1);
        chk("R11 held count", int'(cnt_a), 28);
        chk("R11 held phase", int'(ph_a), 19);

        chk("R2 settle violations", settle_bad, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule